// File: doc/BRIEF.md
# Match-Based Watchdog Timer

This block is a watchdog peripheral that software reaches through a plain synchronous register port of eight 32-bit words. A counter advances once per clock while enabled and is compared with a programmable match value. When the two are equal the block can latch an interrupt flag, halt and zero the counter, change a match output pin, send a one-cycle internal reset request to the system reset controller, and start an active-low external reset pulse whose length is set in a register. Software can also fire either reset request directly without waiting for a match.

A typical kick sequence sets the counter-clear bit, reads the counter until it is zero, programs the match value and actions, and then turns counting on with the debug-freeze bit set. This freezes the count while the debug-halt input is high. A sticky cause bit records that the watchdog requested a reset. It sits on the power-on reset only, so it is still readable after the internal reset that it caused. The register port has no handshake and no back-pressure: every access completes in one cycle. Read data is registered and appears the cycle after the read request. The system must hold `rst_n` low whenever `por_n` is low.

Top module: `wdt_match_timer`

## Requirements
- R1: Word index is address bits [4:2]. Offsets: 0x00 flag, 0x04 control, 0x08 counter (read-only), 0x0C match control, 0x10 match value, 0x14 match output, 0x18 pulse length (16 bits), 0x1C cause (read-only). Writable registers read back what was written, and read data is valid the clock after the request.
- R2: Counting requires control bit 0 = 1 and control bit 1 = 0. The counter then increments by one per clock. While control bit 1 is set, the counter is held at zero.
- R3: When control bit 2 is set and `dbg_halt` is high, the counter holds its value.
- R4: A match occurs when the counter is running and equals the match value. A match sets flag bit 0 at 0x00 on the next clock, and `irq` is that flag ANDed with match control bit 0. Writing 1 to flag bit 0 clears the flag, but a match in the same cycle wins.
- R5: With match control bit 2 set, a match zeroes the counter and clears control bit 0. With bit 2 clear, counting continues past the match.
- R6: `int_rst_req` goes high for one clock after a match with match control bit 3 set. It also goes high for one clock after any write to 0x0C with bit 5 set. Bits 5 and 6 read back as 0.
- R7: `ext_rst_n` goes low on the clock after a match with match control bit 4 set, or after a write to 0x0C with bit 6 set. It stays low for exactly the pulse length + 6 clocks. A trigger while it is low neither extends nor restarts the pulse.
- R8: Bit 0 at 0x14 drives `match_out` and can be written directly. Bits 5:4 select the action on a match: 0 none, 1 drive low, 2 drive high, 3 toggle.
- R9: Cause bit 0 at 0x1C sets whenever an internal or external reset is requested, by match or by force. It survives `rst_n` and is cleared only by `por_n`.
- R10: After reset, every register reads zero, `ext_rst_n` is high, and `irq`, `int_rst_req` and `match_out` are low.
- R11: A write to control or to the match output register in the same cycle as a match takes priority over what the match would do to that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and bus clock |
| rst_n | input | 1 | Active-low block reset, asynchronous |
| por_n | input | 1 | Active-low power-on reset for cause bit and pulse generator |
| dbg_halt | input | 1 | Debugger halt indication |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Match interrupt |
| int_rst_req | output | 1 | One-cycle internal reset request |
| ext_rst_n | output | 1 | Active-low external reset pulse |
| match_out | output | 1 | Match output pin state |

## Verification
Two cases can land on the same clock: a match and a software write to a register that the match also updates. The flag clear at 0x00 and the control write at 0x04 are both provoked this way. The bench uses its reference model to find the exact clock on which the counter will equal the match value, and issues the write on that clock. The result is then judged by reading back the flag, which must stay set, and the run bit, which must keep the written value. A second collision is a forced external reset issued while a pulse is already low. The bench judges this by counting the low cycles of `ext_rst_n`.

// File: rtl/wdt_match_pkg.sv
package wdt_match_pkg;
  typedef enum logic [2:0] {
    RG_FLAG  = 3'd0,
    RG_CTRL  = 3'd1,
    RG_COUNT = 3'd2,
    RG_MCTRL = 3'd3,
    RG_MATCH = 3'd4,
    RG_MOUT  = 3'd5,
    RG_PLEN  = 3'd6,
    RG_CAUSE = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } match_act_e;

  localparam int CTL_RUN  = 0;
  localparam int CTL_CLR  = 1;
  localparam int CTL_FRZ  = 2;
  localparam int MC_IRQ   = 0;
  localparam int MC_STOP  = 2;
  localparam int MC_IRST  = 3;
  localparam int MC_XRST  = 4;
  localparam int MC_FIRST = 5;
  localparam int MC_FXRST = 6;
endpackage

// File: rtl/wdt_mt_counter.sv
module wdt_mt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             clr_req,
  input  logic             frz_en,
  input  logic             dbg_halt,
  input  logic             stop_on_hit,
  input  logic [CNT_W-1:0] mval,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic running;

  assign running = run_en & ~clr_req & ~(frz_en & dbg_halt);
  assign hit     = running && (cnt == mval);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr_req || (hit && stop_on_hit)) begin
      cnt <= '0;
    end else if (running) begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdt_mt_pulse.sv
module wdt_mt_pulse #(
  parameter int PLEN_W = 16,
  parameter int EXTRA  = 6,
  localparam int PC_W  = PLEN_W + 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              trig,
  input  logic [PLEN_W-1:0] plen,
  output logic [PC_W-1:0]   pcnt,
  output logic              pulse_n
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pcnt <= '0;
    end else if (pcnt != '0) begin
      pcnt <= pcnt - PC_W'(1);
    end else if (trig) begin
      pcnt <= PC_W'(plen) + PC_W'(EXTRA);
    end
  end

  assign pulse_n = (pcnt == '0);
endmodule

// File: rtl/wdt_match_timer.sv
module wdt_match_timer
  import wdt_match_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int PLEN_W      = 16,
  parameter int PULSE_EXTRA = 6,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              dbg_halt,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              int_rst_req,
  output logic              ext_rst_n,
  output logic              match_out
);
  localparam int IDX_LSB = 2;
  localparam int PC_W    = PLEN_W + 1;

  reg_idx_e          idx;
  logic              wr_any, rd_any;
  logic              wr_flag, wr_ctl, wr_mctl, wr_match, wr_mout, wr_plen;
  logic [2:0]        ctl_q;
  logic [4:0]        mctl_q;
  logic [CNT_W-1:0]  mval_q;
  logic [CNT_W-1:0]  cnt_w;
  logic              mout_q;
  logic [1:0]        mact_q;
  logic [PLEN_W-1:0] plen_q;
  logic              flag_q, ireq_q, cause_q;
  logic              hit_w, force_int, force_ext, ext_trig, rst_ask;
  logic              frozen_w, clr_w, run_w, stop_w;
  logic [PC_W-1:0]   pcnt_w;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_addr;

  assign unused_addr = ^bus_addr[IDX_LSB-1:0];
  assign idx         = reg_idx_e'(bus_addr[IDX_LSB +: 3]);
  assign wr_any      = bus_sel & bus_wr;
  assign rd_any      = bus_sel & ~bus_wr;
  assign wr_flag     = wr_any && (idx == RG_FLAG);
  assign wr_ctl      = wr_any && (idx == RG_CTRL);
  assign wr_mctl     = wr_any && (idx == RG_MCTRL);
  assign wr_match    = wr_any && (idx == RG_MATCH);
  assign wr_mout     = wr_any && (idx == RG_MOUT);
  assign wr_plen     = wr_any && (idx == RG_PLEN);

  assign force_int   = wr_mctl & bus_wdata[MC_FIRST];
  assign force_ext   = wr_mctl & bus_wdata[MC_FXRST];
  assign ext_trig    = (hit_w & mctl_q[MC_XRST]) | force_ext;
  assign rst_ask     = (hit_w & (mctl_q[MC_IRST] | mctl_q[MC_XRST])) | force_int | force_ext;

  assign run_w       = ctl_q[CTL_RUN];
  assign clr_w       = ctl_q[CTL_CLR];
  assign frozen_w    = ctl_q[CTL_FRZ] & dbg_halt;
  assign stop_w      = mctl_q[MC_STOP];

  wdt_mt_counter #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_w),
    .clr_req    (clr_w),
    .frz_en     (ctl_q[CTL_FRZ]),
    .dbg_halt   (dbg_halt),
    .stop_on_hit(stop_w),
    .mval       (mval_q),
    .cnt        (cnt_w),
    .hit        (hit_w)
  );

  wdt_mt_pulse #(.PLEN_W(PLEN_W), .EXTRA(PULSE_EXTRA)) u_pulse (
    .clk    (clk),
    .por_n  (por_n),
    .trig   (ext_trig),
    .plen   (plen_q),
    .pcnt   (pcnt_w),
    .pulse_n(ext_rst_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      mctl_q <= '0;
      mval_q <= '0;
      mout_q <= 1'b0;
      mact_q <= '0;
      plen_q <= '0;
      flag_q <= 1'b0;
      ireq_q <= 1'b0;
    end else begin
      if (wr_ctl) begin
        ctl_q <= bus_wdata[2:0];
      end else if (hit_w && stop_w) begin
        ctl_q[CTL_RUN] <= 1'b0;
      end

      if (wr_mctl)  mctl_q <= bus_wdata[4:0];
      if (wr_match) mval_q <= bus_wdata[CNT_W-1:0];
      if (wr_plen)  plen_q <= bus_wdata[PLEN_W-1:0];

      if (wr_mout) begin
        mout_q <= bus_wdata[0];
        mact_q <= bus_wdata[5:4];
      end else if (hit_w) begin
        case (match_act_e'(mact_q))
          ACT_LOW:    mout_q <= 1'b0;
          ACT_HIGH:   mout_q <= 1'b1;
          ACT_TOGGLE: mout_q <= ~mout_q;
          default:    mout_q <= mout_q;
        endcase
      end

      if (hit_w) begin
        flag_q <= 1'b1;
      end else if (wr_flag && bus_wdata[0]) begin
        flag_q <= 1'b0;
      end

      ireq_q <= (hit_w & mctl_q[MC_IRST]) | force_int;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cause_q <= 1'b0;
    end else if (rst_ask) begin
      cause_q <= 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (idx)
      RG_FLAG:  rd_mux = DATA_W'(flag_q);
      RG_CTRL:  rd_mux = DATA_W'(ctl_q);
      RG_COUNT: rd_mux = DATA_W'(cnt_w);
      RG_MCTRL: rd_mux = DATA_W'(mctl_q);
      RG_MATCH: rd_mux = DATA_W'(mval_q);
      RG_MOUT:  rd_mux = DATA_W'({mact_q, 3'b000, mout_q});
      RG_PLEN:  rd_mux = DATA_W'(plen_q);
      RG_CAUSE: rd_mux = DATA_W'(cause_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_any) begin
      bus_rdata <= rd_mux;
    end
  end

  assign irq         = flag_q & mctl_q[MC_IRQ];
  assign int_rst_req = ireq_q;
  assign match_out   = mout_q;
endmodule

module wdt_match_timer_chk #(
  parameter int CNT_W = 32,
  parameter int PC_W  = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             por_n,
  input logic             hit,
  input logic             stop_en,
  input logic             ctl_wr,
  input logic             run_en,
  input logic             clr,
  input logic             frozen,
  input logic [CNT_W-1:0] cnt,
  input logic             flag,
  input logic [PC_W-1:0]  pcnt,
  input logic             trig,
  input logic             ext_rst_n,
  input logic             cause
);
  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  assert_freeze_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !clr) |=> $stable(cnt));

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  assert_stop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && stop_en && !ctl_wr) |=> ((cnt == '0) && !run_en));

  assert_pulse_starts_R7: assert property (@(posedge clk) disable iff (!por_n)
    (trig && (pcnt == '0)) |=> !ext_rst_n);

  assert_no_extend_R7: assert property (@(posedge clk) disable iff (!por_n)
    ((pcnt != '0) && trig) |=> (pcnt == $past(pcnt) - PC_W'(1)));

  assert_cause_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
    !$fell(cause));
endmodule

bind wdt_match_timer wdt_match_timer_chk #(.CNT_W(CNT_W), .PC_W(PLEN_W + 1)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .por_n    (por_n),
  .hit      (hit_w),
  .stop_en  (stop_w),
  .ctl_wr   (wr_ctl),
  .run_en   (run_w),
  .clr      (clr_w),
  .frozen   (frozen_w),
  .cnt      (cnt_w),
  .flag     (flag_q),
  .pcnt     (pcnt_w),
  .trig     (ext_trig),
  .ext_rst_n(ext_rst_n),
  .cause    (cause_q)
);

// File: tb/wdt_match_timer_test.sv
`timescale 1ns/1ps
module wdt_match_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_n = 1'b0;
  logic        dbg_halt = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, int_rst_req, ext_rst_n, match_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_match_timer uut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .dbg_halt(dbg_halt),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .int_rst_req(int_rst_req), .ext_rst_n(ext_rst_n), .match_out(match_out)
  );

  // behavioural reference model, advanced once per rising edge
  logic [2:0]  m_ctl = '0;
  logic [31:0] m_cnt = '0;
  logic [4:0]  m_mctl = '0;
  logic [31:0] m_mval = '0;
  logic        m_xs = 1'b0;
  logic [1:0]  m_xa = '0;
  logic [15:0] m_plen = '0;
  logic        m_flag = 1'b0;
  logic        m_ireq = 1'b0;
  logic        m_cause = 1'b0;
  logic [31:0] m_rdata = '0;
  int          m_pc = 0;

  function automatic bit m_running();
    return m_ctl[0] && !m_ctl[1] && !(m_ctl[2] && dbg_halt);
  endfunction

  always @(posedge clk) begin
    if (!por_n) begin
      m_ctl = '0; m_cnt = '0; m_mctl = '0; m_mval = '0; m_xs = 0; m_xa = '0;
      m_plen = '0; m_flag = 0; m_ireq = 0; m_cause = 0; m_rdata = '0; m_pc = 0;
    end else begin
      int   ix;
      bit   w, rd, hit, fi, fx, trig;
      ix   = int'(bus_addr[4:2]);
      w    = bus_sel && bus_wr;
      rd   = bus_sel && !bus_wr;
      hit  = m_running() && (m_cnt == m_mval);
      fi   = w && ix == 3 && bus_wdata[5];
      fx   = w && ix == 3 && bus_wdata[6];
      trig = (hit && m_mctl[4]) || fx;
      if (m_pc != 0) m_pc = m_pc - 1;
      else if (trig) m_pc = int'(m_plen) + 6;
      if ((hit && (m_mctl[3] || m_mctl[4])) || fi || fx) m_cause = 1;
      if (!rst_n) begin
        m_ctl = '0; m_cnt = '0; m_mctl = '0; m_mval = '0; m_xs = 0; m_xa = '0;
        m_plen = '0; m_flag = 0; m_ireq = 0; m_rdata = '0;
      end else begin
        if (rd) begin
          case (ix)
            0: m_rdata = {31'd0, m_flag};
            1: m_rdata = {29'd0, m_ctl};
            2: m_rdata = m_cnt;
            3: m_rdata = {27'd0, m_mctl};
            4: m_rdata = m_mval;
            5: m_rdata = {26'd0, m_xa, 3'd0, m_xs};
            6: m_rdata = {16'd0, m_plen};
            default: m_rdata = {31'd0, m_cause};
          endcase
        end
        m_ireq = (hit && m_mctl[3]) || fi;
        if (hit) m_flag = 1;
        else if (w && ix == 0 && bus_wdata[0]) m_flag = 0;
        if (w && ix == 5) begin
          m_xs = bus_wdata[0]; m_xa = bus_wdata[5:4];
        end else if (hit) begin
          if (m_xa == 1) m_xs = 0;
          else if (m_xa == 2) m_xs = 1;
          else if (m_xa == 3) m_xs = !m_xs;
        end
        if (m_ctl[1] || (hit && m_mctl[2])) m_cnt = 0;
        else if (m_running()) m_cnt = m_cnt + 1;
        if (w && ix == 1) m_ctl = bus_wdata[2:0];
        else if (hit && m_mctl[2]) m_ctl[0] = 0;
        if (w && ix == 3) m_mctl = bus_wdata[4:0];
        if (w && ix == 4) m_mval = bus_wdata;
        if (w && ix == 6) m_plen = bus_wdata[15:0];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(irq === (m_flag & m_mctl[0]), "R4 irq", 32'(irq), 32'(m_flag & m_mctl[0]));
      chk(int_rst_req === m_ireq, "R6 int_rst_req", 32'(int_rst_req), 32'(m_ireq));
      chk(ext_rst_n === (m_pc == 0), "R7 ext_rst_n", 32'(ext_rst_n), 32'(m_pc == 0));
      chk(match_out === m_xs, "R8 match_out", 32'(match_out), 32'(m_xs));
      chk(bus_rdata === m_rdata, "R1 bus_rdata", bus_rdata, m_rdata);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // tasks enter and leave on a falling edge
  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_hit();
    for (int i = 0; i < 2000; i++) begin
      if (m_running() && m_cnt == m_mval) break;
      @(negedge clk);
    end
  endtask

  task automatic arm(input logic [31:0] mv, input logic [31:0] mc);
    bus_write(5'h04, 32'h2);
    bus_write(5'h10, mv);
    bus_write(5'h0C, mc);
    bus_write(5'h04, 32'h1);
  endtask

  initial begin
    logic [31:0] r0, r1;
    int hi, lo;
    bit sent;
    repeat (4) @(negedge clk);
    #1 por_n = 1; rst_n = 1;
    @(negedge clk);
    cmp_on = 1;

    // R10: reset values
    chk(ext_rst_n === 1'b1 && irq === 1'b0 && int_rst_req === 1'b0 && match_out === 1'b0,
        "R10 outputs", {ext_rst_n, irq, int_rst_req, match_out}, 32'h8);
    for (int a = 0; a < 8; a++) begin
      bus_read(5'(a * 4), r0);
      chk(r0 == 0, "R10 register zero", r0, 0);
    end

    // R1: read back
    bus_write(5'h10, 32'h1234_5678);
    bus_read(5'h10, r0);
    chk(r0 == 32'h1234_5678, "R1 match value", r0, 32'h1234_5678);
    bus_write(5'h18, 32'hFFFF_ABCD);
    bus_read(5'h18, r0);
    chk(r0 == 32'h0000_ABCD, "R1 pulse length", r0, 32'hABCD);
    bus_write(5'h0C, 32'h1D);
    bus_read(5'h0C, r0);
    chk(r0 == 32'h1D, "R1 match control", r0, 32'h1D);
    bus_write(5'h0C, 32'h0);

    // R2: counting rate and clear
    bus_write(5'h04, 32'h1);
    bus_read(5'h08, r0); idle(5); bus_read(5'h08, r1);
    chk(r1 - r0 == 6, "R2 count rate", r1 - r0, 6);
    bus_write(5'h04, 32'h3);
    idle(2); bus_read(5'h08, r0);
    chk(r0 == 0, "R2 clear to zero", r0, 0);
    idle(3); bus_read(5'h08, r0);
    chk(r0 == 0, "R2 clear holds", r0, 0);

    // R3: debug freeze
    dbg_halt = 1;
    bus_write(5'h04, 32'h5);
    idle(4);
    bus_read(5'h08, r0); idle(5); bus_read(5'h08, r1);
    chk(r1 == r0, "R3 frozen", r1, r0);
    dbg_halt = 0;
    bus_read(5'h08, r0); idle(5); bus_read(5'h08, r1);
    chk(r1 - r0 == 6, "R3 resumes", r1 - r0, 6);

    // R4 R5 R8: match with stop, drive high
    bus_write(5'h14, 32'h20);
    arm(32'd30, 32'h05);
    hi = 0;
    for (int i = 0; i < 100 && !irq; i++) @(negedge clk);
    chk(irq === 1'b1, "R4 irq after match", 32'(irq), 1);
    chk(match_out === 1'b1, "R8 drive high", 32'(match_out), 1);
    bus_read(5'h04, r0);
    chk(r0[0] == 1'b0, "R5 run bit cleared", r0, 0);
    bus_read(5'h08, r0);
    chk(r0 == 0, "R5 counter zeroed", r0, 0);
    bus_write(5'h00, 32'h1);
    chk(irq === 1'b0, "R4 flag cleared", 32'(irq), 0);

    // R8: toggle action
    bus_write(5'h14, 32'h31);
    arm(32'd5, 32'h04);
    wait_hit(); idle(2);
    chk(match_out === 1'b0, "R8 toggle", 32'(match_out), 0);

    // R4: clear and match in the same cycle, set wins
    arm(32'd8, 32'h05);
    wait_hit();
    bus_write(5'h00, 32'h1);
    bus_read(5'h00, r0);
    chk(r0 == 1, "R4 set beats clear", r0, 1);
    bus_write(5'h00, 32'h1);

    // R11: control write beats stop-on-match
    arm(32'd6, 32'h04);
    wait_hit();
    bus_write(5'h04, 32'h1);
    idle(3);
    bus_read(5'h04, r0);
    chk(r0 == 1, "R11 write wins", r0, 1);

    // R5: no stop, counting continues
    arm(32'd4, 32'h00);
    idle(10);
    bus_read(5'h08, r0);
    chk(r0 > 4, "R5 continues past match", r0, 5);

    // R6: internal reset request on match, then forced
    arm(32'd3, 32'h0C);
    hi = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (int_rst_req) hi++; end
    chk(hi == 1, "R6 one-cycle request", hi, 1);
    bus_write(5'h0C, 32'h20);
    hi = 0;
    for (int i = 0; i < 10; i++) begin if (int_rst_req) hi++; @(negedge clk); end
    chk(hi == 1, "R6 forced request", hi, 1);
    bus_read(5'h0C, r0);
    chk(r0 == 0, "R6 force bits read zero", r0, 0);

    // R7: external pulse with a retrigger while low
    bus_write(5'h18, 32'd10);
    arm(32'd3, 32'h14);
    lo = 0; sent = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!ext_rst_n) lo++;
      if (lo == 5 && !sent) begin
        bus_sel = 1; bus_wr = 1; bus_addr = 5'h0C; bus_wdata = 32'h40; sent = 1;
      end else begin
        bus_sel = 0; bus_wr = 0;
      end
    end
    chk(lo == 16, "R7 pulse length no extend", lo, 16);

    // R7: longest pulse
    bus_write(5'h18, 32'hFFFF);
    bus_write(5'h0C, 32'h40);
    lo = 0;
    for (int i = 0; i < 66000; i++) begin if (!ext_rst_n) lo++; @(negedge clk); end
    chk(lo == 65541, "R7 longest pulse", lo, 65541);

    // R9: cause survives block reset, cleared by power-on reset
    bus_read(5'h1C, r0);
    chk(r0 == 1, "R9 cause set", r0, 1);
    #1 rst_n = 0;
    idle(3);
    #1 rst_n = 1;
    @(negedge clk);
    bus_read(5'h1C, r0);
    chk(r0 == 1, "R9 cause after block reset", r0, 1);
    bus_read(5'h04, r0);
    chk(r0 == 0, "R10 control after block reset", r0, 0);
    #1 por_n = 0; rst_n = 0;
    idle(3);
    #1 por_n = 1; rst_n = 1;
    @(negedge clk);
    bus_read(5'h1C, r0);
    chk(r0 == 0, "R9 cause cleared by power-on", r0, 0);

    idle(2);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule